// File: doc/BRIEF.md
# Byte-Serial Task-File Register Bridge

This block sits on the device side of a narrow 8-bit port and gives a host access to a bank of disk task-file registers and a 256-word sector buffer. After reset the port is locked and behaves as plain pass-through: every read returns 0xFF, and no write reaches the back end. The host opens the port with a fixed three-byte key. It must then perform one read, which returns an acknowledge byte.

Once the port is open, every access starts with a command byte. A register write is the byte sequence ID, low, high. A register read is an ID write followed by two byte reads. Other command bytes do the following:
- start a bulk sector write or a bulk sector read;
- drive the bus reset line;
- sample a command-complete flag;
- lock the port again.

Bulk transfers keep a 16-bit running checksum, which the host reads back through the data-register read ID. The back end is a register model with a combinational read port and a sector buffer. The bridge drives both with single-cycle write strobes.

The host drives one strobe per cycle. If both strobes are high in the same cycle, the write is taken and the read is ignored. `rd_data` is valid in the cycle in which `rd_en` is high, and the bridge advances at the clock edge that ends that cycle.

Top module: `ata_byte_bridge`

## Requirements
- R1: After reset the port is locked, `unlocked` is 0, `ata_reset` is 0, and no back-end write strobe is active.
- R2: Writing 0x72, 0x34 and 0x61 in that order, followed by one read, makes that read return 0xE7. `unlocked` is 1 from the next cycle.
- R3: A key sequence broken by any other byte starts matching again from the first key byte. A 0x72 received at any point counts as the first key byte.
- R4: While locked, every read returns 0xFF (the acknowledge read of R2 excepted), and `rf_wr_en` and `sb_wr_en` stay 0.
- R5: While unlocked and between commands, writing 0xF3 locks the port again.
- R6: A register write is three bytes: the ID, the low byte and the high byte. The third byte produces a single `rf_wr_en` pulse carrying `{high,low}` to the index the ID selects. The IDs and their indices are:
  - 0x6A → 0
  - 0x72 → 1
  - 0xF2 → 2
  - 0x92 → 3
  - 0x52 → 4
  - 0xD2 → 5
  - 0x32 → 6
  - 0xB2 → 7
  - 0x12 → 8
- R7: A register read is an ID write followed by two reads, which return the low byte and then the high byte of the back-end register at the index the ID selects. The IDs and their indices are:
  - 0x68 → 0
  - 0x70 → 1
  - 0xF0 → 2
  - 0x90 → 3
  - 0x50 → 4
  - 0xD0 → 5
  - 0x30 → 6
  - 0xB0 → 7
- R8: An unrecognised byte written between commands has no effect: no strobe fires, reads return 0xFF, and the next byte is decoded as a new command.
- R9: Byte 0x43 starts a bulk write. Each following group of 0x12, low, high writes the word `{high,low}` to sector address i, for i = 0 to 255. After the 256th word the bridge returns to waiting for a command.
- R10: Byte 0x53 starts a bulk read. Reads return sector word i low byte first, for i = 0 to 255. After 512 reads, further reads return 0xFF. Only a written 0x51 ends the mode.
- R11: The checksum clears when either bulk mode starts. Each word i updates it to `cks ^ (word + i)`, truncated to 16 bits. Read ID 0x41 returns the checksum, low byte first.
- R12: Writing 0x13 and then an argument byte sets `ata_reset` to the inverse of bit 0 of the argument. The line holds its value otherwise.
- R13: Writing 0x21 followed by one read returns `{7'b0, cmd_done}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Read byte, valid while rd_en is high |
| unlocked | output | 1 | Port open |
| rf_wr_en | output | 1 | Register-model write strobe |
| rf_wr_addr | output | 4 | Register-model write index |
| rf_wr_data | output | 16 | Register-model write value |
| rf_rd_addr | output | 4 | Register-model read index |
| rf_rd_data | input | 16 | Register-model read value |
| sb_wr_en | output | 1 | Sector-buffer write strobe |
| sb_addr | output | 8 | Sector-buffer word address |
| sb_wr_data | output | 16 | Sector-buffer write word |
| sb_rd_data | input | 16 | Sector-buffer read word |
| cmd_done | input | 1 | Command-complete flag from the back end |
| ata_reset | output | 1 | Bus reset drive, active high |

## Verification
Most internal faults show up at the ports within a few bytes:
- A phase counter that slips makes the next register write land on the wrong index, or fire on the wrong byte, at once.
- A wrong key-match state shows up as a missing 0xE7 on the acknowledge read, or as 0xFF on the first register read.
- A checksum or word-index error stays hidden for a whole sector. It appears only when ID 0x41 is read after the 256th word, or when the bulk read returns its words.

The bench therefore compares every strobe and every read byte against a behavioural model on each cycle, and reads the checksum back after both bulk modes.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

  localparam logic [7:0] KEY0         = 8'h72;
  localparam logic [7:0] KEY1         = 8'h34;
  localparam logic [7:0] KEY2         = 8'h61;
  localparam logic [7:0] KEY_ACK      = 8'hE7;
  localparam logic [7:0] CMD_LOCK     = 8'hF3;
  localparam logic [7:0] CMD_BULK_WR  = 8'h43;
  localparam logic [7:0] CMD_BULK_RD  = 8'h53;
  localparam logic [7:0] CMD_BULK_END = 8'h51;
  localparam logic [7:0] CMD_BUS_RST  = 8'h13;
  localparam logic [7:0] CMD_STATUS   = 8'h21;
  localparam logic [7:0] ID_DATA_WR   = 8'h12;
  localparam logic [3:0] REG_DATA     = 4'd8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_WLO, PH_WHI, PH_RLO, PH_RHI,
    PH_BW_ID, PH_BW_LO, PH_BW_HI, PH_BR, PH_RST, PH_STAT
  } phase_e;

  typedef struct packed {
    logic       hit;
    logic [3:0] idx;
  } reg_sel_t;

  function automatic reg_sel_t map_wr_id(input logic [7:0] id);
    case (id)
      8'h6A:   return '{1'b1, 4'd0};
      8'h72:   return '{1'b1, 4'd1};
      8'hF2:   return '{1'b1, 4'd2};
      8'h92:   return '{1'b1, 4'd3};
      8'h52:   return '{1'b1, 4'd4};
      8'hD2:   return '{1'b1, 4'd5};
      8'h32:   return '{1'b1, 4'd6};
      8'hB2:   return '{1'b1, 4'd7};
      8'h12:   return '{1'b1, 4'd8};
      default: return '{1'b0, 4'd0};
    endcase
  endfunction

  function automatic reg_sel_t map_rd_id(input logic [7:0] id);
    case (id)
      8'h68:   return '{1'b1, 4'd0};
      8'h70:   return '{1'b1, 4'd1};
      8'hF0:   return '{1'b1, 4'd2};
      8'h90:   return '{1'b1, 4'd3};
      8'h50:   return '{1'b1, 4'd4};
      8'hD0:   return '{1'b1, 4'd5};
      8'h30:   return '{1'b1, 4'd6};
      8'hB0:   return '{1'b1, 4'd7};
      8'h41:   return '{1'b1, 4'd8};
      default: return '{1'b0, 4'd0};
    endcase
  endfunction

  function automatic logic [15:0] cks_fold(input logic [15:0] acc,
                                           input logic [15:0] word,
                                           input logic [15:0] idx);
    return acc ^ (word + idx);
  endfunction

endpackage

// File: rtl/ata_bridge_unlock.sv
module ata_bridge_unlock
  import ata_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_take,
  input  logic       lock_req,
  output logic       unlocked,
  output logic       key_ready
);
  logic [1:0] stage;

  assign key_ready = !unlocked && (stage == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      stage    <= 2'd0;
    end else if (unlocked) begin
      if (lock_req) begin
        unlocked <= 1'b0;
        stage    <= 2'd0;
      end
    end else if (wr_en) begin
      if (wr_data == KEY0)                         stage <= 2'd1;
      else if (stage == 2'd1 && wr_data == KEY1)   stage <= 2'd2;
      else if (stage == 2'd2 && wr_data == KEY2)   stage <= 2'd3;
      else                                         stage <= 2'd0;
    end else if (rd_take && stage == 2'd3) begin
      unlocked <= 1'b1;
      stage    <= 2'd0;
    end
  end
endmodule

// File: rtl/ata_bridge_cksum.sv
module ata_bridge_cksum
  import ata_bridge_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [15:0]   word,
  input  logic [IW-1:0] idx,
  output logic [15:0]   cks
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cks <= '0;
    else if (clr) cks <= '0;
    else if (upd) cks <= cks_fold(cks, word, 16'(idx));
  end
endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
  import ata_bridge_pkg::*;
#(
  parameter int SECT_WORDS = 256,
  localparam int IW = $clog2(SECT_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          unlocked,
  output logic          rf_wr_en,
  output logic [3:0]    rf_wr_addr,
  output logic [15:0]   rf_wr_data,
  output logic [3:0]    rf_rd_addr,
  input  logic [15:0]   rf_rd_data,
  output logic          sb_wr_en,
  output logic [IW-1:0] sb_addr,
  output logic [15:0]   sb_wr_data,
  input  logic [15:0]   sb_rd_data,
  input  logic          cmd_done,
  output logic          ata_reset
);
  phase_e      phase, phase_n;
  logic [3:0]  reg_idx, reg_idx_n;
  logic [7:0]  lo_byte, lo_byte_n;
  logic [IW:0] widx, widx_n;
  logic        br_hi, br_hi_n;
  logic        rst_line_n;
  logic        rd_take, key_ready, lock_evt, cks_clr, cks_upd;
  logic [15:0] cks, cks_word, reg_src;
  reg_sel_t    wsel, rsel;

  assign rd_take = rd_en && !wr_en;
  assign wsel    = map_wr_id(wr_data);
  assign rsel    = map_rd_id(wr_data);

  ata_bridge_unlock u_unlock (
    .clk, .rst_n, .wr_en, .wr_data, .rd_take,
    .lock_req(lock_evt), .unlocked, .key_ready
  );

  assign cks_word = (phase == PH_BR) ? sb_rd_data : {wr_data, lo_byte};

  ata_bridge_cksum #(.IW(IW)) u_cksum (
    .clk, .rst_n, .clr(cks_clr), .upd(cks_upd),
    .word(cks_word), .idx(widx[IW-1:0]), .cks
  );

  always_comb begin
    phase_n    = phase;
    reg_idx_n  = reg_idx;
    lo_byte_n  = lo_byte;
    widx_n     = widx;
    br_hi_n    = br_hi;
    rst_line_n = ata_reset;
    rf_wr_en   = 1'b0;
    sb_wr_en   = 1'b0;
    cks_clr    = 1'b0;
    cks_upd    = 1'b0;
    lock_evt   = 1'b0;
    if (!unlocked) begin
      phase_n = PH_IDLE;
    end else if (wr_en) begin
      case (phase)
        PH_WLO: begin lo_byte_n = wr_data; phase_n = PH_WHI; end
        PH_WHI: begin rf_wr_en = 1'b1; phase_n = PH_IDLE; end
        PH_BW_ID: if (wr_data == ID_DATA_WR) phase_n = PH_BW_LO;
        PH_BW_LO: begin lo_byte_n = wr_data; phase_n = PH_BW_HI; end
        PH_BW_HI: begin
          sb_wr_en = 1'b1;
          cks_upd  = 1'b1;
          widx_n   = widx + 1'b1;
          phase_n  = (widx == (IW+1)'(SECT_WORDS-1)) ? PH_IDLE : PH_BW_ID;
        end
        PH_BR:  if (wr_data == CMD_BULK_END) phase_n = PH_IDLE;
        PH_RST: begin rst_line_n = !wr_data[0]; phase_n = PH_IDLE; end
        default: begin
          if (wr_data == CMD_LOCK) begin
            lock_evt = 1'b1;
            phase_n  = PH_IDLE;
          end else if (wsel.hit) begin
            reg_idx_n = wsel.idx;
            phase_n   = PH_WLO;
          end else if (rsel.hit) begin
            reg_idx_n = rsel.idx;
            phase_n   = PH_RLO;
          end else if (wr_data == CMD_BULK_WR) begin
            cks_clr = 1'b1;
            widx_n  = '0;
            phase_n = PH_BW_ID;
          end else if (wr_data == CMD_BULK_RD) begin
            cks_clr = 1'b1;
            widx_n  = '0;
            br_hi_n = 1'b0;
            phase_n = PH_BR;
          end else if (wr_data == CMD_BUS_RST) begin
            phase_n = PH_RST;
          end else if (wr_data == CMD_STATUS) begin
            phase_n = PH_STAT;
          end else begin
            phase_n = PH_IDLE;
          end
        end
      endcase
    end else if (rd_take) begin
      case (phase)
        PH_RLO:  phase_n = PH_RHI;
        PH_RHI:  phase_n = PH_IDLE;
        PH_STAT: phase_n = PH_IDLE;
        PH_BR: if (!widx[IW]) begin
          br_hi_n = !br_hi;
          if (br_hi) begin
            cks_upd = 1'b1;
            widx_n  = widx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      reg_idx   <= '0;
      lo_byte   <= '0;
      widx      <= '0;
      br_hi     <= 1'b0;
      ata_reset <= 1'b0;
    end else begin
      phase     <= phase_n;
      reg_idx   <= reg_idx_n;
      lo_byte   <= lo_byte_n;
      widx      <= widx_n;
      br_hi     <= br_hi_n;
      ata_reset <= rst_line_n;
    end
  end

  assign reg_src = (reg_idx == REG_DATA) ? cks : rf_rd_data;

  always_comb begin
    rd_data = 8'hFF;
    if (!unlocked) begin
      if (key_ready) rd_data = KEY_ACK;
    end else begin
      case (phase)
        PH_RLO:  rd_data = reg_src[7:0];
        PH_RHI:  rd_data = reg_src[15:8];
        PH_STAT: rd_data = {7'b0, cmd_done};
        PH_BR:   if (!widx[IW]) rd_data = br_hi ? sb_rd_data[15:8] : sb_rd_data[7:0];
        default: rd_data = 8'hFF;
      endcase
    end
  end

  assign rf_wr_addr = reg_idx;
  assign rf_wr_data = {wr_data, lo_byte};
  assign rf_rd_addr = reg_idx;
  assign sb_addr    = widx[IW-1:0];
  assign sb_wr_data = {wr_data, lo_byte};
endmodule

// File: rtl/ata_byte_bridge_chk.sv
module ata_byte_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        unlocked,
  input logic        key_ready,
  input logic        rf_wr_en,
  input logic        sb_wr_en,
  input logic        ata_reset,
  input logic        cks_clr,
  input logic        lock_evt,
  input logic [15:0] cks
);
  AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!rf_wr_en && !sb_wr_en)); // R4

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && rd_en && !wr_en) |=> unlocked); // R2

  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && lock_evt) |=> !unlocked); // R5

  AST_RF_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !rf_wr_en); // R6

  AST_CKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cks_clr |=> (cks == 16'h0000)); // R11

  AST_RESET_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ata_reset)); // R12
endmodule

bind ata_byte_bridge ata_byte_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .unlocked(unlocked), .key_ready(key_ready), .rf_wr_en(rf_wr_en),
  .sb_wr_en(sb_wr_en), .ata_reset(ata_reset), .cks_clr(cks_clr),
  .lock_evt(lock_evt), .cks(cks)
);

// File: tb/test_ata_byte_bridge.sv
module test_ata_byte_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, cmd_done = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic unlocked, rf_wr_en, sb_wr_en, ata_reset;
  logic [3:0] rf_wr_addr, rf_rd_addr;
  logic [15:0] rf_wr_data, rf_rd_data, sb_wr_data, sb_rd_data;
  logic [7:0] sb_addr;

  logic [15:0] regs [16];
  logic [15:0] sect [256];
  int checks = 0, errors = 0;

  // behavioural model state
  int m_unl = 0, m_key = 0, m_ph = 0, m_idx = 0, m_lo = 0, m_cnt = 0, m_hi = 0;
  int m_cks = 0, m_rst = 0;
  int wmap [int];
  int rmap [int];

  always #5 clk = ~clk;

  ata_byte_bridge i_ata_byte_bridge (.*);

  always_comb rf_rd_data = regs[rf_rd_addr];
  always_comb sb_rd_data = sect[sb_addr];
  always @(posedge clk) begin
    if (rf_wr_en) regs[rf_wr_addr] <= rf_wr_data;
    if (sb_wr_en) sect[sb_addr] <= sb_wr_data;
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_lines(input string tag);
    chk(tag, int'(unlocked), m_unl, "unlocked");
    chk(tag, int'(ata_reset), m_rst, "ata_reset");
  endtask

  task automatic wr(input int b, input string tag);
    int erf = 0, esb = 0, ea = 0, ed = 0;
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; wr_data = 8'(b);
    #2;
    chk_lines(tag);
    if (m_unl == 0) begin
      if (b == 'h72) m_key = 1;
      else if (m_key == 1 && b == 'h34) m_key = 2;
      else if (m_key == 2 && b == 'h61) m_key = 3;
      else m_key = 0;
    end else begin
      case (m_ph)
        1: begin m_lo = b; m_ph = 2; end
        2: begin erf = 1; ea = m_idx; ed = b * 256 + m_lo; m_ph = 0; end
        5: if (b == 'h12) m_ph = 6;
        6: begin m_lo = b; m_ph = 7; end
        7: begin
          esb = 1; ea = m_cnt; ed = b * 256 + m_lo;
          m_cks = (m_cks ^ (ed + m_cnt)) & 'hFFFF;
          m_cnt++;
          m_ph = (m_cnt == 256) ? 0 : 5;
        end
        8: if (b == 'h51) m_ph = 0;
        9: begin m_rst = (b % 2 == 0) ? 1 : 0; m_ph = 0; end
        default: begin
          if (b == 'hF3) begin m_unl = 0; m_key = 0; m_ph = 0; end
          else if (wmap.exists(b)) begin m_idx = wmap[b]; m_ph = 1; end
          else if (rmap.exists(b)) begin m_idx = rmap[b]; m_ph = 3; end
          else if (b == 'h43) begin m_cks = 0; m_cnt = 0; m_ph = 5; end
          else if (b == 'h53) begin m_cks = 0; m_cnt = 0; m_hi = 0; m_ph = 8; end
          else if (b == 'h13) m_ph = 9;
          else if (b == 'h21) m_ph = 10;
          else m_ph = 0;
        end
      endcase
    end
    chk(tag, int'(rf_wr_en), erf, "rf_wr_en");
    if (erf != 0) begin
      chk(tag, int'(rf_wr_addr), ea, "rf_wr_addr");
      chk(tag, int'(rf_wr_data), ed, "rf_wr_data");
    end
    chk(tag, int'(sb_wr_en), esb, "sb_wr_en");
    if (esb != 0) begin
      chk(tag, int'(sb_addr), ea, "sb_addr");
      chk(tag, int'(sb_wr_data), ed, "sb_wr_data");
    end
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input string tag);
    int e = 'hFF, v, w;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    #2;
    chk_lines(tag);
    if (m_unl == 0) begin
      if (m_key == 3) begin e = 'hE7; m_unl = 1; m_key = 0; m_ph = 0; end
    end else begin
      case (m_ph)
        3: begin v = (m_idx == 8) ? m_cks : int'(regs[m_idx]); e = v % 256; m_ph = 4; end
        4: begin v = (m_idx == 8) ? m_cks : int'(regs[m_idx]); e = v / 256; m_ph = 0; end
        10: begin e = int'(cmd_done); m_ph = 0; end
        8: if (m_cnt < 256) begin
          w = int'(sect[m_cnt]);
          if (m_hi == 0) begin e = w % 256; m_hi = 1; end
          else begin
            e = w / 256; m_hi = 0;
            m_cks = (m_cks ^ (w + m_cnt)) & 'hFFFF;
            m_cnt++;
          end
        end
        default: e = 'hFF;
      endcase
    end
    chk(tag, int'(rd_data), e, "rd_data");
    chk(tag, int'(rf_wr_en | sb_wr_en), 0, "strobe on read");
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  function automatic int pat(input int i);
    return ((i * 'h0101) ^ 'h5A3C) & 'hFFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ids_w [9] = '{'h6A, 'h72, 'hF2, 'h92, 'h52, 'hD2, 'h32, 'hB2, 'h12};
    int ids_r [9] = '{'h68, 'h70, 'hF0, 'h90, 'h50, 'hD0, 'h30, 'hB0, 'h41};
    int ck;
    for (int k = 0; k < 9; k++) begin wmap[ids_w[k]] = k; rmap[ids_r[k]] = k; end
    for (int k = 0; k < 16; k++) regs[k] = 16'(k * 'h1111);
    for (int k = 0; k < 256; k++) sect[k] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", int'(unlocked), 0, "unlocked");
    chk("R1", int'(ata_reset), 0, "ata_reset");
    chk("R1", int'(rf_wr_en | sb_wr_en), 0, "strobes");
    // R4: locked port ignores register traffic
    wr('h6A, "R4"); wr('h11, "R4"); wr('h22, "R4");
    rd("R4"); rd("R4");
    // R3: broken key, then restart on repeated first byte
    wr('h72, "R3"); wr('h34, "R3"); wr('h55, "R3"); wr('h61, "R3"); rd("R3");
    wr('h72, "R3"); wr('h72, "R3"); wr('h34, "R3"); wr('h61, "R3");
    // R2: acknowledge read opens the port
    rd("R2");
    rd("R2");
    // R6: write every register
    for (int k = 0; k < 9; k++) begin
      wr(ids_w[k], "R6"); wr((k * 7 + 3) & 'hFF, "R6"); wr((k * 13 + 'h80) & 'hFF, "R6");
    end
    // R7: read every register other than data
    for (int k = 0; k < 8; k++) begin
      wr(ids_r[k], "R7"); rd("R7"); rd("R7");
    end
    // R8: unknown byte ignored, next byte decoded as command
    wr('h99, "R8"); rd("R8"); wr('h6A, "R8"); wr('hAB, "R8"); wr('hCD, "R8");
    wr('h00, "R8"); wr('h68, "R8"); rd("R8"); rd("R8");
    // R13: status byte
    cmd_done = 1'b1; wr('h21, "R13"); rd("R13");
    cmd_done = 1'b0; wr('h21, "R13"); rd("R13");
    // R12: bus reset assert and release
    wr('h13, "R12"); wr('h00, "R12"); rd("R12");
    wr('h13, "R12"); wr('h01, "R12"); rd("R12");
    // R9, R11: bulk write of a full sector
    wr('h43, "R9");
    for (int i = 0; i < 256; i++) begin
      wr('h12, "R9"); wr(pat(i) & 'hFF, "R9"); wr(pat(i) >> 8, "R9");
    end
    ck = 0;
    for (int i = 0; i < 256; i++) ck = (ck ^ (pat(i) + i)) & 'hFFFF;
    chk("R11", m_cks, ck, "model checksum after bulk write");
    wr('h41, "R11"); rd("R11"); rd("R11");
    // R10, R11: bulk read of the sector back, overrun reads
    wr('h53, "R10");
    for (int i = 0; i < 512; i++) rd("R10");
    rd("R10"); rd("R10");
    wr('h6A, "R10"); rd("R10");
    wr('h51, "R10");
    chk("R11", m_cks, ck, "model checksum after bulk read");
    wr('h41, "R11"); rd("R11"); rd("R11");
    // R5: relock
    wr('hF3, "R5"); rd("R5");
    wr('h6A, "R5"); wr('h01, "R5"); wr('h02, "R5");
    @(negedge clk);
    chk_lines("R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule